// File: doc/BRIEF.md
# Pixel Unpacker With Palette

This block turns one raw layer pixel word into a 32-bit ARGB value with 8 bits per channel. A 3-bit format code comes with each word. Direct colour formats are split into their fields, and each narrow channel is widened to 8 bits. Indexed formats take their colour from a 256-entry colour look-up table, and the alpha for those formats comes from the word itself.

The look-up table is loaded through a single write port. Each write word carries both the entry number and the 24-bit colour. A look-up enable bit in the layer control byte chooses between two paths for indexed formats: the table colour, or a grey level built from the index. Every pixel reaches the output exactly one clock after it is presented, whatever its format, so a pixel stream passes through at one pixel per clock.

Top module: `pxu_unpack`

## Requirements
- R1: While reset is held and in every cycle after it in which outValid is low, outArgb is 0x00000000 and outValid is 0.
- R2: outValid is high in exactly those cycles that follow a cycle with inValid high, and the matching outArgb appears in that same cycle. This holds for back-to-back pixels.
- R3: Code 0 (ARGB8888) outputs the word unchanged. Code 1 (RGB888) outputs {0xFF, word[23:0]}. Neither depends on the look-up enable.
- R4: Code 3 (RGBA8888) takes alpha from word[7:0] and R, G, B from word[31:8], and outputs {word[7:0], word[31:8]}.
- R5: Code 2 (RGB565) outputs alpha 0xFF. Red word[15:11] becomes {r, r[4:2]}, green word[10:5] becomes {g, g[5:4]}, and blue word[4:0] becomes {b, b[4:2]}.
- R6: Code 6 (ARGB1555) maps alpha bit word[15] to 0xFF when it is 1 and to 0x00 when it is 0. The 5-bit channels at word[14:10], word[9:5] and word[4:0] are widened as in R5.
- R7: Code 7 (ARGB4444) takes the nibbles A=word[15:12], R=word[11:8], G=word[7:4] and B=word[3:0], and widens each to {n, n}.
- R8: A cycle with palWrEn high stores palWrData[23:0] (red 23:16, green 15:8, blue 7:0) into entry palWrData[31:24]. Entries 0 through 255 can all be written and read back.
- R9: Code 5 (L8) with layerCtrl[4]=1 outputs {0xFF, table[word[7:0]]}.
- R10: Code 4 (AL44) with layerCtrl[4]=1 outputs {{a,a}, table[{4'h0, i}]}, where a=word[7:4] and i=word[3:0].
- R11: With layerCtrl[4]=0, code 5 outputs {0xFF, v, v, v} with v=word[7:0], and code 4 outputs {{a,a}, g, g, g} with g={i,i}. The other bits of layerCtrl have no effect.
- R12: When a table write and a look-up hit the same entry in the same cycle, the look-up returns the colour stored before the write. Later look-ups return the new colour.
- R13: Word bits outside the selected format's fields have no effect: bits 31:16 for codes 2, 6 and 7, and bits 31:8 for codes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| palWrEn | input | 1 | Look-up table write strobe |
| palWrData | input | 32 | Table write word: entry number in 31:24, colour in 23:0 |
| layerCtrl | input | 8 | Layer control byte; bit 4 enables table look-up |
| inValid | input | 1 | Input pixel qualifier |
| inFormat | input | 3 | Pixel format code |
| inWord | input | 32 | Raw pixel word |
| outValid | output | 1 | Output pixel qualifier |
| outArgb | output | 32 | Unpacked pixel: A 31:24, R 23:16, G 15:8, B 7:0 |

## Verification
The bench targets the widening edges. It uses channel values with only the top bit set, which would show a design that pads with zeros or takes the wrong low bits. It uses all-ones words with the alpha bit clear, which would show an ARGB1555 alpha mapped to the wrong polarity or taken from the wrong bit. It fills the unused upper word bits with junk, so that a field taken from the wrong position gives a visibly wrong colour. On the table side, it looks up an entry in the same cycle that entry is rewritten, which catches a table that forwards write data. It also reads the first and last entries, which catches a truncated address. Finally, it clears the look-up enable while setting every other control bit, which catches a grey path that decodes the wrong bit or sends the index to the table anyway.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  typedef enum logic [2:0] {
    FMT_ARGB32   = 3'd0,
    FMT_RGB24    = 3'd1,
    FMT_RGB16    = 3'd2,
    FMT_RGBA32   = 3'd3,
    FMT_AI8      = 3'd4,
    FMT_IDX8     = 3'd5,
    FMT_ARGB16A1 = 3'd6,
    FMT_ARGB16A4 = 3'd7
  } pixFmt_e;

  // strobes from control to datapath, valid in the input cycle
  typedef struct packed {
    logic palWe;      // store a table entry this cycle
    logic capture;    // an input pixel is accepted this cycle
    logic indexed;    // the format carries an index, not a colour
    logic narrowIdx;  // index is 4 bits with a 4-bit alpha beside it
    logic useLut;     // the index goes through the table
  } ctrlStrobe_t;

endpackage

// File: rtl/pxu_chan_widen.sv
module pxu_chan_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  narrow,
  output logic [OUT_W-1:0] wide
);

  // repeat the channel from its top bit down until the output is full
  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    assign wide[OUT_W-1-k] = narrow[IN_W-1-(k % IN_W)];
  end

endmodule

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [COLOR_W-1:0] wrColor,
  input  logic               rdEn,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [COLOR_W-1:0] rdColor
);

  localparam int DEPTH = 1 << IDX_W;

  logic [COLOR_W-1:0] mem [DEPTH];

  // read-before-write: a same-entry read sees the old content
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx] <= wrColor;
    if (rdEn) rdColor <= mem[rdIdx];
  end

endmodule

// File: rtl/pxu_ctrl.sv
module pxu_ctrl
  import pxu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        palWrEn,
  input  logic        lutOn,
  input  logic        inValid,
  input  pixFmt_e     fmt,
  output ctrlStrobe_t strb,
  output logic        stageValid,
  output logic        stageUsePal
);

  logic isIndexed;

  always_comb begin
    isIndexed      = (fmt == FMT_AI8) || (fmt == FMT_IDX8);
    strb.palWe     = palWrEn;
    strb.capture   = inValid;
    strb.indexed   = isIndexed;
    strb.narrowIdx = (fmt == FMT_AI8);
    strb.useLut    = isIndexed && lutOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid  <= 1'b0;
      stageUsePal <= 1'b0;
    end else begin
      stageValid  <= inValid;
      stageUsePal <= inValid && isIndexed && lutOn;
    end
  end

endmodule

// File: rtl/pxu_datapath.sv
module pxu_datapath
  import pxu_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  pixFmt_e           fmt,
  input  logic [4*CH_W-1:0] inWord,
  input  logic [4*CH_W-1:0] palWrData,
  input  logic              stageValid,
  input  logic              stageUsePal,
  output logic [4*CH_W-1:0] outArgb
);

  localparam int PIX_W   = 4 * CH_W;
  localparam int COLOR_W = 3 * CH_W;
  localparam int NIDX_W  = IDX_W / 2;
  localparam logic [CH_W-1:0] OPAQUE = '1;

  // widened channels of the 16-bit direct formats
  logic [CH_W-1:0] r565, g565, b565;
  logic [CH_W-1:0] r1555, g1555, b1555;
  logic [CH_W-1:0] a4444, r4444, g4444, b4444;
  logic [CH_W-1:0] aNarrow, iNarrow;

  pxu_chan_widen #(.IN_W(5), .OUT_W(CH_W)) wR565  (.narrow(inWord[15:11]), .wide(r565));
  pxu_chan_widen #(.IN_W(6), .OUT_W(CH_W)) wG565  (.narrow(inWord[10:5]),  .wide(g565));
  pxu_chan_widen #(.IN_W(5), .OUT_W(CH_W)) wB565  (.narrow(inWord[4:0]),   .wide(b565));
  pxu_chan_widen #(.IN_W(5), .OUT_W(CH_W)) wR1555 (.narrow(inWord[14:10]), .wide(r1555));
  pxu_chan_widen #(.IN_W(5), .OUT_W(CH_W)) wG1555 (.narrow(inWord[9:5]),   .wide(g1555));
  pxu_chan_widen #(.IN_W(5), .OUT_W(CH_W)) wB1555 (.narrow(inWord[4:0]),   .wide(b1555));
  pxu_chan_widen #(.IN_W(4), .OUT_W(CH_W)) wA4444 (.narrow(inWord[15:12]), .wide(a4444));
  pxu_chan_widen #(.IN_W(4), .OUT_W(CH_W)) wR4444 (.narrow(inWord[11:8]),  .wide(r4444));
  pxu_chan_widen #(.IN_W(4), .OUT_W(CH_W)) wG4444 (.narrow(inWord[7:4]),   .wide(g4444));
  pxu_chan_widen #(.IN_W(4), .OUT_W(CH_W)) wB4444 (.narrow(inWord[3:0]),   .wide(b4444));
  pxu_chan_widen #(.IN_W(NIDX_W), .OUT_W(CH_W)) wANarrow (
    .narrow(inWord[IDX_W-1:NIDX_W]), .wide(aNarrow));
  pxu_chan_widen #(.IN_W(NIDX_W), .OUT_W(CH_W)) wINarrow (
    .narrow(inWord[NIDX_W-1:0]), .wide(iNarrow));

  // indexed formats: embedded alpha, table address and grey fallback
  logic [CH_W-1:0]  idxAlpha;
  logic [CH_W-1:0]  idxGrey;
  logic [IDX_W-1:0] lutAddr;

  always_comb begin
    if (strb.narrowIdx) begin
      idxAlpha = aNarrow;
      idxGrey  = iNarrow;
      lutAddr  = {{(IDX_W-NIDX_W){1'b0}}, inWord[NIDX_W-1:0]};
    end else begin
      idxAlpha = OPAQUE;
      idxGrey  = inWord[CH_W-1:0];
      lutAddr  = inWord[IDX_W-1:0];
    end
  end

  // format select for the value held in the output stage
  logic [PIX_W-1:0] argbNext;

  always_comb begin
    argbNext = '0;
    if (strb.indexed) begin
      argbNext = {idxAlpha, idxGrey, idxGrey, idxGrey};
    end else begin
      case (fmt)
        FMT_ARGB32:   argbNext = inWord;
        FMT_RGB24:    argbNext = {OPAQUE, inWord[COLOR_W-1:0]};
        FMT_RGB16:    argbNext = {OPAQUE, r565, g565, b565};
        FMT_RGBA32:   argbNext = {inWord[CH_W-1:0], inWord[PIX_W-1:CH_W]};
        FMT_ARGB16A1: argbNext = {{CH_W{inWord[15]}}, r1555, g1555, b1555};
        FMT_ARGB16A4: argbNext = {a4444, r4444, g4444, b4444};
        default:      argbNext = '0;
      endcase
    end
  end

  logic [PIX_W-1:0] argbQ;

  always_ff @(posedge clk) begin
    if (!rstN) argbQ <= '0;
    else if (strb.capture) argbQ <= argbNext;
  end

  // colour table, read in the same cycle the pixel is captured
  logic [COLOR_W-1:0] palColor;

  pxu_palette #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) palette_i (
    .clk    (clk),
    .wrEn   (strb.palWe),
    .wrIdx  (palWrData[PIX_W-1:COLOR_W]),
    .wrColor(palWrData[COLOR_W-1:0]),
    .rdEn   (strb.capture && strb.useLut),
    .rdIdx  (lutAddr),
    .rdColor(palColor)
  );

  always_comb begin
    if (!stageValid)     outArgb = '0;
    else if (stageUsePal) outArgb = {argbQ[PIX_W-1:COLOR_W], palColor};
    else                 outArgb = argbQ;
  end

endmodule

// File: rtl/pxu_unpack.sv
module pxu_unpack
  import pxu_pkg::*;
#(
  parameter int CH_W       = 8,
  parameter int IDX_W      = 8,
  parameter int CTRL_W     = 8,
  parameter int LUT_EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              palWrEn,
  input  logic [4*CH_W-1:0] palWrData,
  input  logic [CTRL_W-1:0] layerCtrl,
  input  logic              inValid,
  input  logic [2:0]        inFormat,
  input  logic [4*CH_W-1:0] inWord,
  output logic              outValid,
  output logic [4*CH_W-1:0] outArgb
);

  ctrlStrobe_t strb;
  pixFmt_e     fmt;
  logic        stageValid;
  logic        stageUsePal;
  logic        ctrlUnused;

  assign fmt        = pixFmt_e'(inFormat);
  assign ctrlUnused = ^layerCtrl;

  pxu_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .palWrEn    (palWrEn),
    .lutOn      (layerCtrl[LUT_EN_BIT]),
    .inValid    (inValid),
    .fmt        (fmt),
    .strb       (strb),
    .stageValid (stageValid),
    .stageUsePal(stageUsePal)
  );

  pxu_datapath #(.CH_W(CH_W), .IDX_W(IDX_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .fmt        (fmt),
    .inWord     (inWord),
    .palWrData  (palWrData),
    .stageValid (stageValid),
    .stageUsePal(stageUsePal),
    .outArgb    (outArgb)
  );

  assign outValid = stageValid;

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  layerCtrl,
  input logic        inValid,
  input logic [2:0]  inFormat,
  input logic [31:0] inWord,
  input logic        outValid,
  input logic [31:0] outArgb
);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> outArgb == 32'h0);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFormat == 3'd0) |=> outArgb == $past(inWord));

  a_r3_rgb24_opaque: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFormat == 3'd1) |=> outArgb == {8'hFF, $past(inWord[23:0])});

  a_r4_rgba_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFormat == 3'd3) |=> outArgb == {$past(inWord[7:0]), $past(inWord[31:8])});

  a_r11_grey_l8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFormat == 3'd5 && !layerCtrl[4]) |=>
      outArgb == {8'hFF, {3{$past(inWord[7:0])}}});

endmodule

bind pxu_unpack pxu_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .layerCtrl(layerCtrl),
  .inValid  (inValid),
  .inFormat (inFormat),
  .inWord   (inWord),
  .outValid (outValid),
  .outArgb  (outArgb)
);

// File: tb/pxu_unpack_tb.sv
module pxu_unpack_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        palWrEn = 1'b0;
  logic [31:0] palWrData = '0;
  logic [7:0]  layerCtrl = '0;
  logic        inValid = 1'b0;
  logic [2:0]  inFormat = '0;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic [31:0] outArgb;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pxu_unpack dut_i (
    .clk(clk), .rstN(rstN), .palWrEn(palWrEn), .palWrData(palWrData),
    .layerCtrl(layerCtrl), .inValid(inValid), .inFormat(inFormat),
    .inWord(inWord), .outValid(outValid), .outArgb(outArgb)
  );

  // table fill pattern: R=k, G=~k, B=k^A5
  function automatic logic [23:0] palColor(input logic [7:0] k);
    return {k, ~k, k ^ 8'hA5};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // {req, ctrl, fmt, word, expected}
  localparam int NV = 18;
  localparam logic [82:0] VECS [NV] = '{
    {8'd3,  8'h00, 3'd0, 32'h12345678, 32'h12345678},  // R3
    {8'd3,  8'h00, 3'd1, 32'hAB123456, 32'hFF123456},  // R3
    {8'd4,  8'h00, 3'd3, 32'h11223344, 32'h44112233},  // R4
    {8'd5,  8'h00, 3'd2, 32'h0000F800, 32'hFFFF0000},  // R5
    {8'd5,  8'h00, 3'd2, 32'h000007E0, 32'hFF00FF00},  // R5
    {8'd13, 8'h00, 3'd2, 32'h12348410, 32'hFF848284},  // R13 R5
    {8'd6,  8'h00, 3'd6, 32'h00008000, 32'hFF000000},  // R6
    {8'd13, 8'h00, 3'd6, 32'hFFFF7FFF, 32'h00FFFFFF},  // R13 R6
    {8'd6,  8'h00, 3'd6, 32'h00004210, 32'h00848484},  // R6
    {8'd7,  8'h00, 3'd7, 32'h00001234, 32'h11223344},  // R7
    {8'd7,  8'h00, 3'd7, 32'hABCDF0A5, 32'hFF00AA55},  // R7
    {8'd9,  8'h10, 3'd5, 32'h00000003, 32'hFF03FCA6},  // R9
    {8'd13, 8'h1F, 3'd5, 32'hFFFFFF80, 32'hFF807F25},  // R13 R9
    {8'd10, 8'h10, 3'd4, 32'h000000C5, 32'hCC05FAA0},  // R10
    {8'd10, 8'h10, 3'd4, 32'hFFFFFF3F, 32'h330FF0AA},  // R10
    {8'd11, 8'hEF, 3'd5, 32'h00000042, 32'hFF424242},  // R11
    {8'd11, 8'h00, 3'd4, 32'h000000A7, 32'hAA777777},  // R11
    {8'd3,  8'h10, 3'd0, 32'hDEADBEEF, 32'hDEADBEEF}   // R3
  };

  task automatic send(input logic [7:0] ctrl, input logic [2:0] fmt, input logic [31:0] word);
    @(negedge clk);
    layerCtrl = ctrl; inFormat = fmt; inWord = word; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outValid", {31'd0, outValid}, 32'd0);
    check("R1 reset outArgb", outArgb, 32'd0);
    rstN = 1'b1;

    // R8 fill every table entry
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      palWrEn = 1'b1;
      palWrData = {k[7:0], palColor(k[7:0])};
    end
    @(negedge clk);
    palWrEn = 1'b0;

    // vector table
    for (int v = 0; v < NV; v++) begin
      send(VECS[v][74:67], VECS[v][66:64], VECS[v][63:32]);
      check($sformatf("R%0d vec%0d valid", VECS[v][82:75], v), {31'd0, outValid}, 32'd1);
      check($sformatf("R%0d vec%0d", VECS[v][82:75], v), outArgb, VECS[v][31:0]);
    end

    // R1 R2 idle after a pixel
    @(negedge clk);
    check("R2 idle outValid", {31'd0, outValid}, 32'd0);
    check("R1 idle outArgb", outArgb, 32'd0);

    // R2 back-to-back pixels
    @(negedge clk);
    layerCtrl = 8'h00; inFormat = 3'd0; inWord = 32'hCAFE0001; inValid = 1'b1;
    @(negedge clk);
    check("R2 stream first", outArgb, 32'hCAFE0001);
    check("R2 stream first valid", {31'd0, outValid}, 32'd1);
    inFormat = 3'd1; inWord = 32'h00BEEF02;
    @(negedge clk);
    check("R2 stream second", outArgb, 32'hFFBEEF02);
    inValid = 1'b0;
    @(negedge clk);
    check("R2 stream end", {31'd0, outValid}, 32'd0);

    // R8 boundary entries
    send(8'h10, 3'd5, 32'h00000000);
    check("R8 entry 0", outArgb, {8'hFF, palColor(8'h00)});
    send(8'h10, 3'd5, 32'h000000FF);
    check("R8 entry 255", outArgb, {8'hFF, palColor(8'hFF)});

    // R12 same-entry write and look-up in one cycle
    @(negedge clk);
    palWrEn = 1'b1; palWrData = 32'h09112233;
    layerCtrl = 8'h10; inFormat = 3'd5; inWord = 32'h00000009; inValid = 1'b1;
    @(negedge clk);
    palWrEn = 1'b0; inValid = 1'b0;
    check("R12 old colour", outArgb, {8'hFF, palColor(8'h09)});
    send(8'h10, 3'd5, 32'h00000009);
    check("R12 R8 new colour", outArgb, 32'hFF112233);

    // R8 rewrite last entry, read through AL44 cannot reach it; use L8
    @(negedge clk);
    palWrEn = 1'b1; palWrData = 32'hFF0A0B0C;
    @(negedge clk);
    palWrEn = 1'b0;
    send(8'h10, 3'd5, 32'h000000FF);
    check("R8 rewritten 255", outArgb, 32'hFF0A0B0C);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule